// File: doc/BRIEF.md
# Demand-Driven Work Farm Dispatcher

This block is the master of a small work farm. After a start pulse it hands out the item indices 0 to C-1 to N worker ports. C is a runtime count latched at start. It never splits the list up front. Every worker first gets one index. After that, each accepted result is answered at once with the next unassigned index for the same worker. Fast workers therefore take more items than slow ones.

When no index is left, each worker whose result has come back receives a stop token instead of an item. Every returned result carries a score and a payload. The master keeps the winning result: the highest score, with ties going to the lower item index. After the last stop token has been taken, the master pulses `done` and presents the winner on its best-result outputs.

Each worker port has two channels. The item channel carries either an index or a stop token, and a transfer happens when the valid and request signals are both high in a cycle. The result channel carries a score and a payload, and a result is taken in the cycle when its valid and ready signals are both high.

Top module: `workFarmMaster`

## Requirements
- R1: After reset, `itemValid`, `resReady`, `busy`, `done` and `bestValid` are all low.
- R2: A start pulse while idle latches `itemCount` = C and raises `busy`. From the next cycle on, worker w is offered item index w (`itemValid`=1, `itemStop`=0) when w < C, and a stop token (`itemValid`=1, `itemStop`=1) otherwise. An offer holds steady until `itemReq` takes it.
- R3: When a result from worker w is accepted, `itemValid[w]` is high in the very next cycle. It offers the lowest index not yet handed out, or a stop token if every index has been handed out.
- R4: Every index in 0..C-1 is dispatched exactly once, and no index at or above C is ever dispatched. Exactly C results are accepted per run.
- R5: `resReady[w]` is high only while worker w holds an item it has taken and not yet answered. A result presented by a worker that holds no item is never accepted and does not affect the best result.
- R6: At most one `resReady` bit is high per cycle. Pending results are granted round-robin, so a worker holding a valid result is accepted within N cycles.
- R7: Each worker receives exactly one stop token per run. A worker receives it only when it has no outstanding item.
- R8: `done` is high for exactly one cycle: the cycle after the last stop token is taken. `busy` is low from that same cycle on.
- R9: At `done`, `bestScore` is the maximum score among the accepted results. `bestIndex` is the lowest item index that reached that score, and `bestPayload` is that result's payload. `bestValid` is 1 exactly when C > 0.
- R10: A start pulse while `busy` is high is ignored: the running count, dispatch order and final result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| itemCount | input | IDX_W | Number of items for the run |
| itemReq | input | N | Worker w can take an item or stop token |
| itemValid | output | N | Offer pending to worker w |
| itemStop | output | N | Offer to worker w is a stop token |
| itemIndex | output | N*IDX_W | Item index offered to worker w (slice w) |
| resValid | input | N | Worker w presents a result |
| resReady | output | N | Result from worker w accepted this cycle |
| resScore | input | N*SCORE_W | Result score from worker w |
| resPayload | input | N*PAY_W | Result payload from worker w |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| bestValid | output | 1 | At least one result was merged |
| bestScore | output | SCORE_W | Winning score |
| bestIndex | output | IDX_W | Item index of the winning result |
| bestPayload | output | PAY_W | Payload of the winning result |

## Verification
Two functions can fall in the same cycle. In the first case, several workers finish together and compete for the single result slot while the refill of the previous winner is being offered. In the second case, one worker's result is accepted in the same cycle as another worker's item or stop handshake. The bench provokes both by giving every worker the same latency, so that all results arrive together. It also gates `itemReq` on a rotating pattern, so that offers wait while results are being granted. Each accepted result is judged against an order-tracking model in the bench: the refill index must follow acceptance order, the wait must stay within N cycles, and `done` must land exactly one cycle after the final stop handshake.

// File: rtl/wfPkg.sv
package wfPkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_OFFER_ITEM,
    W_BUSY,
    W_OFFER_STOP,
    W_DONE
  } workerStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic startLoad;  // run launched this cycle
    logic accept;     // one result taken this cycle
    logic refill;     // granted worker gets the next index
  } dpCtrlT;

endpackage

// File: rtl/wfRrArbiter.sv
module wfRrArbiter #(
  parameter int N = 4,
  localparam int WID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [WID_W-1:0] grantId,
  output logic             anyGrant
);

  logic [WID_W-1:0] ptr;

  always_comb begin
    grant    = '0;
    grantId  = '0;
    anyGrant = 1'b0;
    for (int i = 0; i < N; i++) begin
      int cand;
      cand = int'(ptr) + i;
      if (cand >= N) cand = cand - N;
      if (!anyGrant && req[cand]) begin
        anyGrant    = 1'b1;
        grant[cand] = 1'b1;
        grantId     = WID_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (anyGrant) ptr <= (grantId == WID_W'(N - 1)) ? '0 : grantId + 1'b1;
  end

endmodule

// File: rtl/wfControl.sv
module wfControl
  import wfPkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 8,
  localparam int WID_W = (N > 1) ? $clog2(N) : 1,
  localparam int OUT_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] itemCount,
  input  logic [N-1:0]     itemReq,
  input  logic [N-1:0]     resValid,
  output logic [N-1:0]     itemValid,
  output logic [N-1:0]     itemStop,
  output logic [N-1:0]     resReady,
  output logic [WID_W-1:0] grantId,
  output logic [IDX_W-1:0] nextIdx,
  output dpCtrlT           ctrl,
  output logic             busy,
  output logic             done,
  output logic [OUT_W-1:0] outstanding
);

  workerStateT      st [N];
  logic [IDX_W-1:0] countReg;
  logic             running;
  logic [N-1:0]     busyMask, doneMask, grant;
  logic             anyGrant, launch, refill;
  logic [OUT_W-1:0] issueCnt;

  always_comb begin
    for (int w = 0; w < N; w++) begin
      busyMask[w]  = (st[w] == W_BUSY);
      doneMask[w]  = (st[w] == W_DONE);
      itemValid[w] = (st[w] == W_OFFER_ITEM) || (st[w] == W_OFFER_STOP);
      itemStop[w]  = (st[w] == W_OFFER_STOP);
    end
  end

  wfRrArbiter #(.N(N)) arb (
    .clk     (clk),
    .rstN    (rstN),
    .req     (resValid & busyMask),
    .grant   (grant),
    .grantId (grantId),
    .anyGrant(anyGrant)
  );

  assign resReady = grant;
  assign launch   = start && !running;
  assign refill   = anyGrant && (nextIdx < countReg);
  assign issueCnt = OUT_W'($countones(itemValid & itemReq & ~itemStop));
  assign busy     = running;

  always_comb begin
    ctrl.startLoad = launch;
    ctrl.accept    = anyGrant;
    ctrl.refill    = refill;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < N; w++) st[w] <= W_IDLE;
    end else begin
      for (int w = 0; w < N; w++) begin
        if (launch) begin
          st[w] <= (w < int'(itemCount)) ? W_OFFER_ITEM : W_OFFER_STOP;
        end else begin
          case (st[w])
            W_OFFER_ITEM: if (itemReq[w]) st[w] <= W_BUSY;
            W_BUSY:       if (grant[w]) st[w] <= refill ? W_OFFER_ITEM : W_OFFER_STOP;
            W_OFFER_STOP: if (itemReq[w]) st[w] <= W_DONE;
            default:      st[w] <= st[w];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running     <= 1'b0;
      done        <= 1'b0;
      countReg    <= '0;
      nextIdx     <= '0;
      outstanding <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        running     <= 1'b1;
        countReg    <= itemCount;
        nextIdx     <= (int'(itemCount) < N) ? itemCount : IDX_W'(N);
        outstanding <= '0;
      end else begin
        if (refill) nextIdx <= nextIdx + 1'b1;
        outstanding <= outstanding + issueCnt - OUT_W'(anyGrant);
        if (running && (&doneMask)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wfDatapath.sv
module wfDatapath
  import wfPkg::*;
#(
  parameter int N       = 4,
  parameter int IDX_W   = 8,
  parameter int SCORE_W = 8,
  parameter int PAY_W   = 8,
  localparam int WID_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrlT             ctrl,
  input  logic [WID_W-1:0]   grantId,
  input  logic [IDX_W-1:0]   nextIdx,
  input  logic [N*SCORE_W-1:0] resScore,
  input  logic [N*PAY_W-1:0] resPayload,
  output logic [N*IDX_W-1:0] itemIndex,
  output logic               bestValid,
  output logic [SCORE_W-1:0] bestScore,
  output logic [IDX_W-1:0]   bestIndex,
  output logic [PAY_W-1:0]   bestPayload
);

  logic [IDX_W-1:0]   slot [N];
  logic [SCORE_W-1:0] selScore;
  logic [PAY_W-1:0]   selPay;
  logic [IDX_W-1:0]   selIdx;
  logic               better;

  for (genvar w = 0; w < N; w++) begin : g_idx
    assign itemIndex[w*IDX_W +: IDX_W] = slot[w];
  end

  assign selScore = resScore[grantId*SCORE_W +: SCORE_W];
  assign selPay   = resPayload[grantId*PAY_W +: PAY_W];
  assign selIdx   = slot[grantId];
  assign better   = !bestValid || (selScore > bestScore) ||
                    ((selScore == bestScore) && (selIdx < bestIndex));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < N; w++) slot[w] <= '0;
    end else begin
      for (int w = 0; w < N; w++) begin
        if (ctrl.startLoad) slot[w] <= IDX_W'(w);
        else if (ctrl.refill && grantId == WID_W'(w)) slot[w] <= nextIdx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.startLoad) begin
      bestValid   <= 1'b0;
      bestScore   <= '0;
      bestIndex   <= '0;
      bestPayload <= '0;
    end else if (ctrl.accept && better) begin
      bestValid   <= 1'b1;
      bestScore   <= selScore;
      bestIndex   <= selIdx;
      bestPayload <= selPay;
    end
  end

endmodule

// File: rtl/workFarmMaster.sv
module workFarmMaster
  import wfPkg::*;
#(
  parameter int N       = 4,
  parameter int IDX_W   = 8,
  parameter int SCORE_W = 8,
  parameter int PAY_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [IDX_W-1:0]     itemCount,
  input  logic [N-1:0]         itemReq,
  output logic [N-1:0]         itemValid,
  output logic [N-1:0]         itemStop,
  output logic [N*IDX_W-1:0]   itemIndex,
  input  logic [N-1:0]         resValid,
  output logic [N-1:0]         resReady,
  input  logic [N*SCORE_W-1:0] resScore,
  input  logic [N*PAY_W-1:0]   resPayload,
  output logic                 busy,
  output logic                 done,
  output logic                 bestValid,
  output logic [SCORE_W-1:0]   bestScore,
  output logic [IDX_W-1:0]     bestIndex,
  output logic [PAY_W-1:0]     bestPayload
);

  localparam int WID_W = (N > 1) ? $clog2(N) : 1;
  localparam int OUT_W = $clog2(N + 1);

  dpCtrlT           ctrl;
  logic [WID_W-1:0] grantId;
  logic [IDX_W-1:0] nextIdx;
  logic [OUT_W-1:0] outstanding;

  wfControl #(.N(N), .IDX_W(IDX_W)) ctl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .itemCount  (itemCount),
    .itemReq    (itemReq),
    .resValid   (resValid),
    .itemValid  (itemValid),
    .itemStop   (itemStop),
    .resReady   (resReady),
    .grantId    (grantId),
    .nextIdx    (nextIdx),
    .ctrl       (ctrl),
    .busy       (busy),
    .done       (done),
    .outstanding(outstanding)
  );

  wfDatapath #(.N(N), .IDX_W(IDX_W), .SCORE_W(SCORE_W), .PAY_W(PAY_W)) dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .grantId    (grantId),
    .nextIdx    (nextIdx),
    .resScore   (resScore),
    .resPayload (resPayload),
    .itemIndex  (itemIndex),
    .bestValid  (bestValid),
    .bestScore  (bestScore),
    .bestIndex  (bestIndex),
    .bestPayload(bestPayload)
  );

endmodule

// File: rtl/workFarmChecker.sv
module workFarmChecker #(
  parameter int N     = 4,
  parameter int IDX_W = 8,
  parameter int OUT_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [N-1:0]       itemReq,
  input logic [N-1:0]       itemValid,
  input logic [N-1:0]       itemStop,
  input logic [N*IDX_W-1:0] itemIndex,
  input logic [N-1:0]       resValid,
  input logic [N-1:0]       resReady,
  input logic               busy,
  input logic               done,
  input logic [OUT_W-1:0]   outstanding
);

  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resReady)); // R6

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (resReady & ~resValid) == '0); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (resReady == '0 && itemValid == '0)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (outstanding == '0 && !busy)); // R7

  for (genvar w = 0; w < N; w++) begin : g_hold
    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (itemValid[w] && !itemReq[w]) |=>
        (itemValid[w] && $stable(itemStop[w]) && $stable(itemIndex[w*IDX_W +: IDX_W]))); // R2
  end

endmodule

bind workFarmMaster workFarmChecker #(.N(N), .IDX_W(IDX_W), .OUT_W($clog2(N + 1))) chk (
  .clk        (clk),
  .rstN       (rstN),
  .itemReq    (itemReq),
  .itemValid  (itemValid),
  .itemStop   (itemStop),
  .itemIndex  (itemIndex),
  .resValid   (resValid),
  .resReady   (resReady),
  .busy       (busy),
  .done       (done),
  .outstanding(outstanding)
);

// File: tb/workFarmMaster_test.sv
module workFarmMaster_test;
  localparam int N  = 4;
  localparam int IW = 6;
  localparam int SW = 8;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] itemCount = '0;
  logic [N-1:0] itemReq = '0, resValid = '0;
  logic [N-1:0] itemValid, itemStop, resReady;
  logic [N*IW-1:0] itemIndex;
  logic [N*SW-1:0] resScore = '0;
  logic [N*PW-1:0] resPayload = '0;
  logic busy, done, bestValid;
  logic [SW-1:0] bestScore;
  logic [IW-1:0] bestIndex;
  logic [PW-1:0] bestPayload;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk; // 8 time units = 125 MHz

  workFarmMaster #(.N(N), .IDX_W(IW), .SCORE_W(SW), .PAY_W(PW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .itemCount(itemCount),
    .itemReq(itemReq), .itemValid(itemValid), .itemStop(itemStop),
    .itemIndex(itemIndex), .resValid(resValid), .resReady(resReady),
    .resScore(resScore), .resPayload(resPayload), .busy(busy), .done(done),
    .bestValid(bestValid), .bestScore(bestScore), .bestIndex(bestIndex),
    .bestPayload(bestPayload)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int scoreOf(input int idx, input int seed);
    return ((idx * 13 + seed * 5) % 9) * 17;
  endfunction

  function automatic int payOf(input int idx);
    return (idx ^ 8'hA5) & 8'hFF;
  endfunction

  function automatic int latOf(input int w, input int idx, input int mode);
    if (mode == 0) return 2;
    if (mode == 1) return w + 1;
    return (idx % 3) + 1;
  endfunction

  // worker models
  bit  hold [N];
  bit  stopped [N];
  bit  pendStop [N];
  bit  immCheck [N];
  int  heldIdx [N];
  int  timer [N];
  int  stopCnt [N];
  int  pendExp [N];
  int  waitCnt [N];
  bit  seen [64];

  task automatic runOne(input int count, input int mode, input bit gateReq,
                        input bit spur, input bit lateStart, input int seed);
    int nextExp, resultsAcc, doneStage, cyc, bs, bi;
    bit finished;
    logic [N-1:0] itemFire, resFire, stopSnap;
    logic [N*IW-1:0] idxSnap;
    for (int i = 0; i < 64; i++) seen[i] = 1'b0;
    for (int w = 0; w < N; w++) begin
      hold[w] = 0; stopped[w] = 0; immCheck[w] = 0; stopCnt[w] = 0;
      waitCnt[w] = 0; timer[w] = 0; heldIdx[w] = 0;
      pendStop[w] = (w >= count);
      pendExp[w] = w;
    end
    nextExp = (count < N) ? count : N;
    resultsAcc = 0; doneStage = 0; finished = 0;
    resValid = '0; itemReq = '0;
    @(posedge clk); #1;
    start = 1'b1; itemCount = IW'(count);
    @(posedge clk); #1;
    start = 1'b0;
    for (int w = 0; w < N; w++) itemReq[w] = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int w = 0; w < N; w++) begin
      check(itemValid[w] == 1'b1, "R2 initial offer", int'(itemValid[w]), 1);
      check(itemStop[w] == (w >= count), "R2 initial stop flag", int'(itemStop[w]), int'(w >= count));
      if (w < count)
        check(int'(itemIndex[w*IW +: IW]) == w, "R2 initial index", int'(itemIndex[w*IW +: IW]), w);
    end
    for (cyc = 0; cyc < 1000 && !finished; cyc++) begin
      // sample phase
      if (cyc > 0) @(negedge clk);
      for (int w = 0; w < N; w++) begin
        if (immCheck[w]) begin
          check(itemValid[w] == 1'b1, "R3 immediate refill", int'(itemValid[w]), 1);
          immCheck[w] = 0;
        end
        if (stopped[w] && resValid[w])
          check(resReady[w] == 1'b0, "R5 idle worker result refused", int'(resReady[w]), 0);
      end
      check($countones(resReady) <= 1, "R6 single grant", $countones(resReady), 1);
      if (doneStage == 2) begin
        check(done == 1'b1, "R8 done timing", int'(done), 1);
        check(busy == 1'b0, "R8 busy falls", int'(busy), 0);
        bs = -1; bi = 0;
        for (int i = 0; i < count; i++)
          if (scoreOf(i, seed) > bs) begin bs = scoreOf(i, seed); bi = i; end
        check(bestValid == (count > 0), "R9 bestValid", int'(bestValid), int'(count > 0));
        if (count > 0) begin
          check(int'(bestScore) == bs, "R9 best score", int'(bestScore), bs);
          check(int'(bestIndex) == bi, "R9 best index", int'(bestIndex), bi);
          check(int'(bestPayload) == payOf(bi), "R9 best payload", int'(bestPayload), payOf(bi));
        end
        finished = 1;
      end else if (done) begin
        check(1'b0, "R8 early done", 1, 0);
      end
      itemFire = itemValid & itemReq;
      resFire  = resValid & resReady;
      stopSnap = itemStop;
      idxSnap  = itemIndex;
      if (finished) break;
      // apply phase
      @(posedge clk); #1;
      if (doneStage == 1) doneStage = 2;
      if (lateStart) begin
        if (cyc == 2) begin start = 1'b1; itemCount = IW'(count + 5); end
        if (cyc == 3) start = 1'b0;
      end
      for (int w = 0; w < N; w++) begin
        if (itemFire[w]) begin
          if (stopSnap[w]) begin
            check(pendStop[w] && !hold[w], "R7 stop only when drained", int'(hold[w]), 0);
            check(!stopped[w], "R7 single stop token", stopCnt[w] + 1, 1);
            stopped[w] = 1; stopCnt[w]++;
          end else begin
            int idx;
            idx = int'(idxSnap[w*IW +: IW]);
            check(!pendStop[w] && idx == pendExp[w], "R3 refill index order", idx, pendExp[w]);
            check(idx < count, "R4 index in range", idx, count - 1);
            check(idx >= 64 || !seen[idx], "R4 index unique", idx, -1);
            if (idx < 64) seen[idx] = 1;
            hold[w] = 1; heldIdx[w] = idx; timer[w] = latOf(w, idx, mode);
          end
        end
        if (resFire[w]) begin
          if (stopped[w]) check(1'b0, "R5 spurious result accepted", 1, 0);
          check(waitCnt[w] <= N, "R6 round-robin wait", waitCnt[w], N);
          resultsAcc++;
          resValid[w] = 1'b0; hold[w] = 0; immCheck[w] = 1;
          if (nextExp < count) begin pendExp[w] = nextExp; nextExp++; end
          else pendStop[w] = 1;
        end
      end
      begin
        bit allStop;
        allStop = 1;
        for (int w = 0; w < N; w++) allStop &= stopped[w];
        if (allStop && doneStage == 0) doneStage = 1;
      end
      for (int w = 0; w < N; w++) begin
        if (hold[w] && !resValid[w]) begin
          timer[w]--;
          if (timer[w] <= 0) begin
            resValid[w] = 1'b1; waitCnt[w] = 1;
            resScore[w*SW +: SW]   = SW'(scoreOf(heldIdx[w], seed));
            resPayload[w*PW +: PW] = PW'(payOf(heldIdx[w]));
          end
        end else if (hold[w] && resValid[w]) begin
          waitCnt[w]++;
        end
        if (spur && stopped[w]) begin
          resValid[w] = 1'b1;
          resScore[w*SW +: SW] = '1;
          resPayload[w*PW +: PW] = '1;
        end
        itemReq[w] = !hold[w] && !stopped[w] && !(gateReq && ((cyc % 3) == (w % 3)));
      end
    end
    if (!finished) check(1'b0, "R8 run watchdog", cyc, 1000);
    check(resultsAcc == count, "R4 result count", resultsAcc, count);
    for (int i = 0; i < count; i++) check(seen[i], "R4 index dispatched", i, 1);
    for (int w = 0; w < N; w++) check(stopCnt[w] == 1, "R7 stop per worker", stopCnt[w], 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    resValid = '0; itemReq = '0;
  endtask

  initial begin
    #1600000;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(itemValid == '0, "R1 reset itemValid", int'(itemValid), 0);
    check(resReady == '0, "R1 reset resReady", int'(resReady), 0);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(bestValid == 1'b0, "R1 reset bestValid", int'(bestValid), 0);
    for (int mode = 0; mode < 3; mode++)
      for (int g = 0; g < 2; g++)
        for (int c = 0; c <= 12; c++)
          runOne(c, mode, g[0], g[0], (mode == 1 && c >= 6), c + mode); // R10 via lateStart
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule